// File: doc/BRIEF.md
# Thermal-Aware Per-Core Frequency and Idle Governor

This block decides, once per unit of work, how fast one processing core should run and whether it must be parked in a power-down state. Firmware brackets each frame of work with a start strobe and a done strobe. The block latches a free-running time counter at the start strobe. At the done strobe it measures the elapsed time and compares it with two limits: a worst-case task budget and the frame period. It also compares the current die temperature code with three thresholds. Elapsed time above the budget raises the speed by one level, provided the core is not yet warm. Time left over lowers the speed by one level, which reclaims slack. Running past the frame period drops the next frame.

A temperature above the critical threshold overrides every timing decision and parks the core in a selected power-down mode. The park is kept, and new frames are refused, until the temperature falls below the low threshold. The low and high thresholds form a hysteresis band. Their reset values of 70 °C and 90 °C keep the die under a 95 °C budget. All thresholds, both time limits and the park mode sit in small writable registers.

Top module: `thermal_dvfs_gov`

## Requirements
- R1: After reset: freq_lvl_o=0, idle_mode_o=0, frame_skip_o=0, frame_busy_o=0. Low, high and critical thresholds are 70, 90 and 92. The task budget is 100 ticks, the frame period is 200 ticks and the park mode is Idle3.
- R2: freq_lvl_o encodes five levels: 0=500 MHz, 1=375 MHz, 2=187.5 MHz, 3=68.75 MHz, 4=clock stopped. It changes only on an evaluation, by at most one level, and never leaves 0..4.
- R3: An evaluation with temp ≤ critical, elapsed ≤ period, elapsed > budget and temp < high lowers freq_lvl_o by one (faster), saturating at 0.
- R4: An evaluation with temp ≤ critical, elapsed ≤ period and elapsed < budget raises freq_lvl_o by one (slower), saturating at 4.
- R5: An evaluation with temp ≤ critical and elapsed ≤ period holds freq_lvl_o when elapsed equals the budget, or when elapsed exceeds the budget and temp ≥ high.
- R6: An evaluation with temp ≤ critical and elapsed > period pulses frame_skip_o for exactly one cycle and holds freq_lvl_o.
- R7: An evaluation with temp > critical holds freq_lvl_o, gives no skip pulse and sets idle_mode_o to the park mode. idle_mode_o codes: 0=active, 1=Idle0, 2=Idle1, 3=Idle2, 4=Idle3, 5=NoFetch.
- R8: While parked, frame_start_i is ignored (frame_busy_o stays 0). idle_mode_o returns to 0 on the clock edge at which temp_i < low is sampled, and not while temp_i ≥ low.
- R9: An accepted frame_start_i sets frame_busy_o and latches time_i. task_done_i while busy is an evaluation and clears frame_busy_o. task_done_i while not busy has no effect. frame_start_i while busy has no effect.
- R10: A write with cfg_we_i selects a register by cfg_addr_i: 0 low, 1 high, 2 critical (low 8 data bits), 3 budget, 4 period, 5 park mode. The park mode takes values 0..4 (Idle0, Idle1, Idle2, Idle3, NoFetch), and a write above 4 is ignored.
- R11: Elapsed time is time_i minus the latched start, modulo 2^16, so a counter wrap between start and done is measured correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| temp_i | input | 8 | Die temperature, whole °C |
| time_i | input | 16 | Free-running time counter |
| frame_start_i | input | 1 | Frame start strobe |
| task_done_i | input | 1 | Task completion strobe |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 3 | Register select |
| cfg_wdata_i | input | 16 | Register write data |
| freq_lvl_o | output | 3 | Frequency level index |
| idle_mode_o | output | 3 | Power-down mode request |
| frame_skip_o | output | 1 | One-cycle drop-next-frame pulse |
| frame_busy_o | output | 1 | Frame in progress |

## Verification
The assertions check several properties on every cycle:
- the level stays in range and moves by at most one step, and only on an evaluation;
- the skip strobe lasts a single cycle;
- parking leaves the level unchanged;
- no frame runs while parked;
- the core is released as soon as the temperature is sampled below the low threshold.

Which way the level moves for a given mix of elapsed time and temperature, how the three decisions rank against each other, the threshold edges, saturation, the counter wrap and the register writes can only be shown by the bench. It sweeps elapsed times around the budget and the period against temperatures around each threshold, and compares every outcome with an arithmetic model.

// File: rtl/gov_pkg.sv
package gov_pkg;
  localparam int NUM_LVL = 5;
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int MODE_W  = 3;

  localparam logic [2:0] A_LOW    = 3'd0;
  localparam logic [2:0] A_HIGH   = 3'd1;
  localparam logic [2:0] A_CRIT   = 3'd2;
  localparam logic [2:0] A_BUDGET = 3'd3;
  localparam logic [2:0] A_PERIOD = 3'd4;
  localparam logic [2:0] A_PARK   = 3'd5;

  typedef enum logic [MODE_W-1:0] {
    IM_ACTIVE, IM_IDLE0, IM_IDLE1, IM_IDLE2, IM_IDLE3, IM_NOFETCH
  } idle_mode_e;

  typedef enum logic [1:0] {STEP_HOLD, STEP_UP, STEP_DOWN} step_e;

  typedef struct packed {
    logic  hot;
    logic  skip;
    step_e step;
  } verdict_t;
endpackage

// File: rtl/gov_cfg_regs.sv
module gov_cfg_regs #(
  parameter int TEMP_W     = 8,
  parameter int TIME_W     = 16,
  parameter int LOW_RST    = 70,
  parameter int HIGH_RST   = 90,
  parameter int CRIT_RST   = 92,
  parameter int BUDGET_RST = 100,
  parameter int PERIOD_RST = 200,
  parameter int PARK_RST   = 3,
  parameter int PARK_MAX   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [TIME_W-1:0] wdata_i,
  output logic [TEMP_W-1:0] thr_low_o,
  output logic [TEMP_W-1:0] thr_high_o,
  output logic [TEMP_W-1:0] thr_crit_o,
  output logic [TIME_W-1:0] budget_o,
  output logic [TIME_W-1:0] period_o,
  output logic [2:0]        park_o
);
  import gov_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_low_o  <= TEMP_W'(LOW_RST);
      thr_high_o <= TEMP_W'(HIGH_RST);
      thr_crit_o <= TEMP_W'(CRIT_RST);
      budget_o   <= TIME_W'(BUDGET_RST);
      period_o   <= TIME_W'(PERIOD_RST);
      park_o     <= 3'(PARK_RST);
    end else if (we_i) begin
      unique case (addr_i)
        A_LOW:    thr_low_o  <= wdata_i[TEMP_W-1:0];
        A_HIGH:   thr_high_o <= wdata_i[TEMP_W-1:0];
        A_CRIT:   thr_crit_o <= wdata_i[TEMP_W-1:0];
        A_BUDGET: budget_o   <= wdata_i;
        A_PERIOD: period_o   <= wdata_i;
        A_PARK:   if (wdata_i <= TIME_W'(PARK_MAX)) park_o <= wdata_i[2:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gov_frame_timer.sv
module gov_frame_timer #(
  parameter int TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              task_done_i,
  input  logic              block_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              busy_o,
  output logic              eval_o,
  output logic [TIME_W-1:0] elapsed_o
);
  logic [TIME_W-1:0] start_q;

  assign eval_o    = busy_o & task_done_i;
  // modular difference tolerates counter wrap
  assign elapsed_o = time_i - start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      start_q <= '0;
    end else if (busy_o) begin
      if (task_done_i) busy_o <= 1'b0;
    end else if (frame_start_i && !block_i) begin
      busy_o  <= 1'b1;
      start_q <= time_i;
    end
  end
endmodule

// File: rtl/gov_policy.sv
module gov_policy #(
  parameter int TEMP_W = 8,
  parameter int TIME_W = 16
) (
  input  logic [TEMP_W-1:0]  temp_i,
  input  logic [TIME_W-1:0]  elapsed_i,
  input  logic [TIME_W-1:0]  budget_i,
  input  logic [TIME_W-1:0]  period_i,
  input  logic [TEMP_W-1:0]  thr_high_i,
  input  logic [TEMP_W-1:0]  thr_crit_i,
  output gov_pkg::verdict_t  verdict_o
);
  import gov_pkg::*;

  logic over_crit, overrun, late, early, warm;

  assign over_crit = temp_i > thr_crit_i;
  assign overrun   = elapsed_i > period_i;
  assign late      = elapsed_i > budget_i;
  assign early     = elapsed_i < budget_i;
  assign warm      = temp_i >= thr_high_i;

  // priority: critical park, then overrun, then slack step
  always_comb begin
    verdict_o = '{hot: 1'b0, skip: 1'b0, step: STEP_HOLD};
    if (over_crit)          verdict_o.hot  = 1'b1;
    else if (overrun)       verdict_o.skip = 1'b1;
    else if (late && !warm) verdict_o.step = STEP_UP;
    else if (early)         verdict_o.step = STEP_DOWN;
  end
endmodule

// File: rtl/thermal_dvfs_gov.sv
module thermal_dvfs_gov #(
  parameter int TEMP_W     = 8,
  parameter int TIME_W     = 16,
  parameter int LOW_RST    = 70,
  parameter int HIGH_RST   = 90,
  parameter int CRIT_RST   = 92,
  parameter int BUDGET_RST = 100,
  parameter int PERIOD_RST = 200,
  parameter int PARK_RST   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              frame_start_i,
  input  logic              task_done_i,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [TIME_W-1:0] cfg_wdata_i,
  output logic [2:0]        freq_lvl_o,
  output logic [2:0]        idle_mode_o,
  output logic              frame_skip_o,
  output logic              frame_busy_o
);
  import gov_pkg::*;

  localparam logic [LVL_W-1:0] LVL_TOP = '0;
  localparam logic [LVL_W-1:0] LVL_BOT = LVL_W'(NUM_LVL - 1);

  logic [TEMP_W-1:0] thr_low, thr_high, thr_crit;
  logic [TIME_W-1:0] budget, period, elapsed;
  logic [2:0]        park;
  logic              eval, hot_q, skip_q;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  verdict_t          verdict;

  gov_cfg_regs #(
    .TEMP_W(TEMP_W), .TIME_W(TIME_W), .LOW_RST(LOW_RST), .HIGH_RST(HIGH_RST),
    .CRIT_RST(CRIT_RST), .BUDGET_RST(BUDGET_RST), .PERIOD_RST(PERIOD_RST),
    .PARK_RST(PARK_RST), .PARK_MAX(NUM_LVL - 1)
  ) i_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .thr_low_o(thr_low), .thr_high_o(thr_high), .thr_crit_o(thr_crit),
    .budget_o(budget), .period_o(period), .park_o(park)
  );

  gov_frame_timer #(.TIME_W(TIME_W)) i_timer (
    .clk_i, .rst_ni, .frame_start_i, .task_done_i, .block_i(hot_q), .time_i,
    .busy_o(frame_busy_o), .eval_o(eval), .elapsed_o(elapsed)
  );

  gov_policy #(.TEMP_W(TEMP_W), .TIME_W(TIME_W)) i_policy (
    .temp_i, .elapsed_i(elapsed), .budget_i(budget), .period_i(period),
    .thr_high_i(thr_high), .thr_crit_i(thr_crit), .verdict_o(verdict)
  );

  always_comb begin
    lvl_d = lvl_q;
    if (eval) begin
      unique case (verdict.step)
        STEP_UP:   if (lvl_q != LVL_TOP) lvl_d = lvl_q - 1'b1;
        STEP_DOWN: if (lvl_q != LVL_BOT) lvl_d = lvl_q + 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= LVL_TOP;
      hot_q  <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      skip_q <= eval & verdict.skip;
      if (eval && verdict.hot)        hot_q <= 1'b1;
      else if (hot_q && temp_i < thr_low) hot_q <= 1'b0;
    end
  end

  assign freq_lvl_o   = 3'(lvl_q);
  assign frame_skip_o = skip_q;
  assign idle_mode_o  = hot_q ? (park + 3'd1) : 3'(IM_ACTIVE);
endmodule

// File: rtl/gov_checker.sv
module gov_checker #(
  parameter int TEMP_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [TEMP_W-1:0] temp_i,
  input logic [TEMP_W-1:0] thr_low,
  input logic              task_done_i,
  input logic [2:0]        freq_lvl_o,
  input logic [2:0]        idle_mode_o,
  input logic              frame_skip_o,
  input logic              frame_busy_o
);
  a_r2_lvl_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_lvl_o <= 3'd4);

  a_r2_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (task_done_i && frame_busy_o) |=>
      (freq_lvl_o == $past(freq_lvl_o) || freq_lvl_o == $past(freq_lvl_o) + 3'd1 ||
       freq_lvl_o + 3'd1 == $past(freq_lvl_o)));

  a_r2_no_eval_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(task_done_i && frame_busy_o) |=> $stable(freq_lvl_o));

  a_r6_skip_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_skip_o |=> !frame_skip_o);

  a_r7_park_holds_lvl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_mode_o != 3'd0) |-> $stable(freq_lvl_o));

  a_r7_park_no_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_mode_o != 3'd0) |-> !frame_skip_o);

  a_r8_no_frame_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_mode_o != 3'd0) |-> !frame_busy_o);

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_mode_o != 3'd0 && temp_i < thr_low) |=> idle_mode_o == 3'd0);
endmodule

bind thermal_dvfs_gov gov_checker #(.TEMP_W(TEMP_W)) i_gov_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .temp_i(temp_i), .thr_low(thr_low),
  .task_done_i(task_done_i), .freq_lvl_o(freq_lvl_o), .idle_mode_o(idle_mode_o),
  .frame_skip_o(frame_skip_o), .frame_busy_o(frame_busy_o)
);

// File: tb/test_thermal_dvfs_gov.sv
module test_thermal_dvfs_gov;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  temp = 8'd50;
  logic [15:0] tnow = '0, wdata = '0;
  logic        fstart = 0, tdone = 0, we = 0;
  logic [2:0]  addr = '0;
  logic [2:0]  lvl, mode;
  logic        skip, busy;

  int n_run = 0, n_fail = 0;
  int m_lvl = 0, m_park = 3, m_low = 70, m_high = 90, m_crit = 92;
  int m_budget = 100, m_period = 200;
  bit m_hot = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_dvfs_gov i_thermal_dvfs_gov (
    .clk_i(clk), .rst_ni(rst_n), .temp_i(temp), .time_i(tnow),
    .frame_start_i(fstart), .task_done_i(tdone), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .freq_lvl_o(lvl),
    .idle_mode_o(mode), .frame_skip_o(skip), .frame_busy_o(busy)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic cfg_write(int a, int d);
    @(negedge clk); we = 1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk); we = 0;
  endtask

  // one frame: start at t0, done after e ticks at temperature t; checks at the negedge after evaluation
  task automatic frame(int t0, int e, int t);
    string tag;
    int exp_skip = 0;
    @(negedge clk); tnow = 16'(t0); fstart = 1;
    @(negedge clk); fstart = 0;
    chk("R9", int'(busy), 1);
    tnow = 16'(t0 + e); temp = 8'(t); tdone = 1;
    @(negedge clk); tdone = 0;
    if (t > m_crit) begin tag = "R7"; m_hot = 1; end
    else if (e > m_period) begin tag = "R6"; exp_skip = 1; end
    else if (e > m_budget && t < m_high) begin tag = "R3"; if (m_lvl > 0) m_lvl--; end
    else if (e < m_budget) begin tag = "R4"; if (m_lvl < 4) m_lvl++; end
    else tag = "R5";
    chk(tag, int'(lvl), m_lvl);
    chk(tag, int'(skip), exp_skip);
    chk(tag, int'(mode), m_hot ? m_park + 1 : 0);
    chk("R9", int'(busy), 0);
    if (exp_skip == 1) begin
      @(negedge clk);
      chk("R6", int'(skip), 0);
    end
  endtask

  // park state: refuse a frame, hold at the low threshold, release below it
  task automatic cool();
    @(negedge clk); temp = 8'(m_low); fstart = 1;
    @(negedge clk); fstart = 0;
    chk("R8", int'(busy), 0);
    chk("R8", int'(mode), m_park + 1);
    tdone = 1;
    @(negedge clk); tdone = 0;
    chk("R9", int'(lvl), m_lvl);
    temp = 8'(m_low - 1);
    @(negedge clk);
    m_hot = 0;
    chk("R8", int'(mode), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int elist[6] = '{50, 99, 100, 101, 200, 201};
    int tlist[6] = '{60, 89, 90, 91, 92, 93};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", int'(lvl), 0);
    chk("R1", int'(mode), 0);
    chk("R1", int'(skip), 0);
    chk("R1", int'(busy), 0);

    // stray done with no frame
    tdone = 1; tnow = 16'd500;
    @(negedge clk); tdone = 0;
    chk("R9", int'(lvl), 0);

    // R4 saturation at bottom, R3 saturation at top
    for (int i = 0; i < 6; i++) frame(0, 10, 50);
    chk("R4", int'(lvl), 4);
    for (int i = 0; i < 6; i++) frame(0, 150, 50);
    chk("R3", int'(lvl), 0);

    // sweep elapsed times against temperatures, several passes from different levels
    for (int p = 0; p < 3; p++)
      for (int ei = 0; ei < 6; ei++)
        for (int ti = 0; ti < 6; ti++) begin
          frame(p * 7, elist[ei], tlist[ti]);
          if (m_hot) cool();
        end

    // R11: counter wrap
    frame(16'hFFF0, 32, 50);
    frame(16'hFFF0, 101, 50);
    frame(16'hFFC0, 201, 50);

    // R9: second start while busy is ignored (elapsed measured from first)
    @(negedge clk); tnow = 16'd1000; fstart = 1;
    @(negedge clk); tnow = 16'd1080;
    @(negedge clk); fstart = 0; tnow = 16'd1101; temp = 8'd50; tdone = 1;
    @(negedge clk); tdone = 0;
    if (m_lvl > 0) m_lvl--;
    chk("R9", int'(lvl), m_lvl);

    // R10: register writes
    cfg_write(1, 80); m_high = 80;
    frame(0, 150, 85);
    cfg_write(5, 4); m_park = 4;
    cfg_write(5, 7);
    cfg_write(2, 60); m_crit = 60;
    cfg_write(0, 50); m_low = 50;
    frame(0, 150, 61);
    chk("R10", int'(mode), 5);
    @(negedge clk); temp = 8'd55;
    @(negedge clk);
    chk("R10", int'(mode), 5);
    cool();
    cfg_write(3, 20); m_budget = 20;
    cfg_write(4, 40); m_period = 40;
    frame(0, 30, 40);
    frame(0, 10, 40);
    frame(0, 41, 40);

    summary();
  end
endmodule